// File: doc/BRIEF.md
# Circular Audio Playback DMA Channel

This block is one playback channel of an audio DMA engine. It reads 32-bit sample words from a ring buffer in memory and places them in an internal sample FIFO, from which an audio consumer pops one word at a time. Software sets the ring's start address, its size and the interrupt period, then starts the channel. The channel requests 4-beat incrementing bursts whenever the FIFO runs low. When the ring is used up, it continues from the start address without a gap.

Software learns where the channel is through a live current-address register. Three sticky status bits tell it about events: a period of words has arrived from memory, the consumer found the FIFO empty, or memory answered with an error. Each status bit is cleared by writing a one to it. A per-bit enable decides which status bits drive the interrupt line. The usual start sequence is: clear all status, set the enables, then set the run bit.

Top module: `audio_ring_dma`

## Requirements
- R1: After reset every register reads zero, `mem_req` and `irq` are low and `smp_empty` is high.
- R2: Register offsets on `cfg_addr` are 0 control (bit 0 = run), 1 ring start (bits 1:0 always read zero), 2 ring size in words minus one, 3 period in words minus one, 4 current address (read-only), 5 interrupt enables (bits 2:0) and 6 status (bits 2:0). A write takes effect at the clock edge, and `cfg_rdata` shows the addressed register combinationally.
- R3: A burst of 4 beats is requested at the current address only when all of the following hold: the channel runs, it is not halted, no burst is outstanding, and FIFO occupancy is at or below 8 words. Occupancy never exceeds the FIFO depth.
- R4: Words reach `smp_data` in address order from the start address up to start + 4 × size-field, then continue from the start address. The ring size in words is a multiple of 4.
- R5: The current address equals start + 4 × (words accepted since the channel was last stopped, modulo the ring size).
- R6: Status bit 0 (period) is set on every (period-field + 1)-th word accepted from memory.
- R7: Writing ones to offset 6 clears the matching status bits. If a bit is set and cleared in the same cycle, setting wins.
- R8: `irq` is high exactly while some status bit and its enable bit are both one.
- R9: A pop while the FIFO is empty and the channel runs sets status bit 1 (underrun). A pop while the channel is stopped changes nothing.
- R10: A beat returned with `mem_rerr` sets status bit 2 and is discarded, along with the rest of its burst. No further bursts are requested until control is written with run = 0 and then with run = 1, after which fetching restarts at the start address.
- R11: Writing run = 0 stops new requests, empties the FIFO and returns the current address to the start address. Beats already in flight are drained and discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset for reads and writes |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Addressed register contents |
| mem_req | output | 1 | Burst request, held until granted |
| mem_addr | output | 32 | Burst start address |
| mem_gnt | input | 1 | Burst accepted this cycle |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | 32 | Read beat data |
| mem_rerr | input | 1 | Read beat carries an access error |
| smp_pop | input | 1 | Consumer takes one word |
| smp_data | output | 32 | Word at the FIFO head |
| smp_empty | output | 1 | FIFO holds no words |
| irq | output | 1 | Interrupt line |

## Verification
Results appear at different times:
- A register write shows on `cfg_rdata` in the cycle after its edge.
- `mem_req` follows FIFO occupancy and the busy state with no register delay.
- A beat accepted at one edge is poppable and counted in the current address right after that edge.
- A status bit and `irq` rise in the cycle after the beat or pop that caused them.

The bench drives and samples only at falling edges, reads registers one step after setting the offset, and polls `smp_empty` before each data check. Where bursts must finish, it waits a fixed number of cycles that covers three or four full bursts of its memory model before comparing status or address.

// File: rtl/audio_ring_dma.sv
module audio_ring_dma #(
  parameter int AW    = 32,
  parameter int LW    = 16,
  parameter int DEPTH = 16,
  parameter int WM    = 8,
  parameter int BEATS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_gnt,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_rerr,
  input  logic          smp_pop,
  output logic [31:0]   smp_data,
  output logic          smp_empty,
  output logic          irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam int BW = $clog2(BEATS);

  logic          run, halt, busy, drop;
  logic [AW-1:0] base, cur;
  logic [LW-1:0] blen, plen, wofs, pcnt;
  logic [2:0]    ien, stat, clr, set;
  logic [BW-1:0] beat;
  logic [31:0]   fifo [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  wire wr_ctl  = cfg_we && cfg_addr == 3'd0;
  wire stop    = wr_ctl && !cfg_wdata[0];
  wire grant   = mem_req && mem_gnt;
  wire live    = mem_rvalid && busy && !drop;
  wire take    = live && !mem_rerr;
  wire berr    = live && mem_rerr;
  wire pop     = smp_pop && cnt != '0;
  wire xrun    = smp_pop && cnt == '0 && run;
  wire per_hit = take && pcnt == plen;

  assign cur       = base + AW'({wofs, 2'b00});
  assign mem_addr  = cur;
  assign mem_req   = run && !halt && !busy && cnt <= CW'(WM);
  assign smp_empty = cnt == '0;
  assign smp_data  = fifo[rp];
  assign irq       = |(stat & ien);
  assign clr       = (cfg_we && cfg_addr == 3'd6) ? cfg_wdata[2:0] : 3'b000;
  assign set       = {berr, xrun, per_hit};

  always_comb begin
    case (cfg_addr)
      3'd0:    cfg_rdata = {31'b0, run};
      3'd1:    cfg_rdata = 32'(base);
      3'd2:    cfg_rdata = 32'(blen);
      3'd3:    cfg_rdata = 32'(plen);
      3'd4:    cfg_rdata = 32'(cur);
      3'd5:    cfg_rdata = {29'b0, ien};
      3'd6:    cfg_rdata = {29'b0, stat};
      default: cfg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0; base <= '0; blen <= '0; plen <= '0; ien <= '0; stat <= '0;
    end else begin
      if (cfg_we) begin
        case (cfg_addr)
          3'd0: run  <= cfg_wdata[0];
          3'd1: base <= {cfg_wdata[AW-1:2], 2'b00};
          3'd2: blen <= cfg_wdata[LW-1:0];
          3'd3: plen <= cfg_wdata[LW-1:0];
          3'd5: ien  <= cfg_wdata[2:0];
          default: ;
        endcase
      end
      stat <= (stat & ~clr) | set;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; drop <= 1'b0; halt <= 1'b0; beat <= '0;
      wofs <= '0; pcnt <= '0;
    end else begin
      if (grant) begin
        busy <= 1'b1; beat <= '0; drop <= 1'b0;
      end else if (mem_rvalid && busy) begin
        beat <= beat + 1'b1;
        if (beat == BW'(BEATS - 1)) busy <= 1'b0;
      end
      if (berr) begin
        halt <= 1'b1; drop <= 1'b1;
      end
      if (stop) begin
        halt <= 1'b0;
        if (busy || grant) drop <= 1'b1;
        wofs <= '0; pcnt <= '0;
      end else if (take) begin
        wofs <= (wofs == blen) ? '0 : wofs + 1'b1;
        pcnt <= per_hit ? '0 : pcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take) fifo[wp] <= mem_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || stop) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      wp  <= wp + PW'(take);
      rp  <= rp + PW'(pop);
      cnt <= cnt + CW'(take) - CW'(pop);
    end
  end
endmodule

module audio_ring_dma_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_gnt,
  input logic          mem_rvalid,
  input logic          mem_rerr,
  input logic          smp_pop,
  input logic          smp_empty,
  input logic [2:0]    stat,
  input logic [CW-1:0] cnt
);
  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(DEPTH)); // R3
  AST_ONE_BURST_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && mem_gnt) |=> !mem_req); // R3
  AST_PERIOD_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n) $rose(stat[0]) |-> $past(mem_rvalid)); // R6
  AST_XRUN_ON_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n) $rose(stat[1]) |-> $past(smp_pop && smp_empty)); // R9
  AST_ERR_ON_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(stat[2]) |-> $past(mem_rvalid && mem_rerr)); // R10
  AST_NO_REQ_AFTER_ERR: assert property (@(posedge clk) disable iff (!rst_n) $rose(stat[2]) |-> !mem_req); // R10
endmodule

bind audio_ring_dma audio_ring_dma_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_gnt(mem_gnt),
  .mem_rvalid(mem_rvalid), .mem_rerr(mem_rerr), .smp_pop(smp_pop),
  .smp_empty(smp_empty), .stat(stat), .cnt(cnt)
);

// File: tb/sim_audio_ring_dma.sv
module sim_audio_ring_dma;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, mem_gnt = 1'b0, mem_rvalid = 1'b0, mem_rerr = 1'b0, smp_pop = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata, mem_addr, mem_rdata = '0, smp_data;
  logic mem_req, smp_empty, irq;
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  logic [31:0] cap = '0, baddr = '0, r;
  int pend = 0, nchk = 0, nbad = 0;

  always #5 clk = ~clk;

  audio_ring_dma u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_rerr(mem_rerr),
    .smp_pop(smp_pop), .smp_data(smp_data), .smp_empty(smp_empty), .irq(irq)
  );

  // memory model: returns each word's own address as its data
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_gnt = 1'b0; mem_rvalid = 1'b0; mem_rerr = 1'b0; pend = 0;
    end else begin
      if (mem_gnt) begin
        mem_gnt = 1'b0; pend = 4; baddr = cap;
      end
      if (pend > 0) begin
        mem_rvalid = 1'b1; mem_rdata = baddr; mem_rerr = (baddr == err_addr);
        baddr = baddr + 4; pend = pend - 1;
      end else begin
        mem_rvalid = 1'b0; mem_rerr = 1'b0;
      end
      if (mem_req && pend == 0 && !mem_rvalid) begin
        mem_gnt = 1'b1; cap = mem_addr;
      end
    end
  end

  typedef struct packed {
    logic [31:0] base;
    logic [15:0] blen;
    logic [15:0] plen;
    int unsigned n;
  } vec_t;
  localparam vec_t VT [3] = '{
    '{32'h0000_1000, 16'd7,  16'd3, 20},
    '{32'h0000_2000, 16'd11, 16'd5, 30},
    '{32'h0000_3F00, 16'd3,  16'd0, 10}
  };

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    cfg_addr = a; #1; d = cfg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic popw(input logic [31:0] exp, input string rq);
    int t = 0;
    while (smp_empty && t < 200) begin @(negedge clk); t++; end
    chk(!smp_empty && smp_data == exp, rq, smp_data, exp);
    smp_pop = 1'b1;
    @(negedge clk); smp_pop = 1'b0;
  endtask

  task automatic raw_pop;
    @(negedge clk); smp_pop = 1'b1;
    @(negedge clk); smp_pop = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    nbad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end

  initial begin
    idle(3); rst_n = 1'b1; idle(1);
    // R1 reset state
    rd(3'd0, r); chk(r == 0, "R1", r, 0);
    rd(3'd6, r); chk(r == 0, "R1", r, 0);
    chk(!mem_req && !irq && smp_empty, "R1", {mem_req, irq, smp_empty}, 3'b001);

    // R2 register map
    wr(3'd1, 32'h0000_7007); rd(3'd1, r); chk(r == 32'h7004, "R2", r, 32'h7004);
    wr(3'd2, 32'h0000_1234); rd(3'd2, r); chk(r == 32'h1234, "R2", r, 32'h1234);
    wr(3'd5, 32'h7);         rd(3'd5, r); chk(r == 32'h7, "R2", r, 32'h7);
    rd(3'd4, r); chk(r == 32'h7004, "R5", r, 32'h7004);
    wr(3'd5, 32'h0);

    // R3 R4 table of ring configurations
    for (int v = 0; v < 3; v++) begin
      wr(3'd0, 0); wr(3'd1, VT[v].base); wr(3'd2, 32'(VT[v].blen));
      wr(3'd3, 32'(VT[v].plen)); wr(3'd6, 7); wr(3'd0, 1);
      for (int i = 0; i < int'(VT[v].n); i++)
        popw(VT[v].base + 32'(4 * (i % (int'(VT[v].blen) + 1))), "R3/R4");
    end
    wr(3'd0, 0);

    // R6 R7 R8 period, clear and gating
    wr(3'd1, 32'h4000); wr(3'd2, 15); wr(3'd3, 3); wr(3'd6, 7); wr(3'd5, 1); wr(3'd0, 1);
    idle(40);
    rd(3'd6, r); chk(r == 1, "R6", r, 1);
    chk(irq == 1'b1, "R8", irq, 1);
    chk(!mem_req, "R3", mem_req, 0);
    rd(3'd4, r); chk(r == 32'h4030, "R5", r, 32'h4030);
    wr(3'd5, 0); chk(irq == 1'b0, "R8", irq, 0);
    wr(3'd5, 1);
    wr(3'd6, 1); rd(3'd6, r); chk(r == 0, "R7", r, 0);
    chk(irq == 1'b0, "R8", irq, 0);
    for (int i = 0; i < 4; i++) popw(32'h4000 + 32'(4 * i), "R4");
    idle(20);
    rd(3'd6, r); chk(r == 1, "R6", r, 1);
    rd(3'd4, r); chk(r == 32'h4000, "R5", r, 32'h4000);
    wr(3'd5, 0);

    // R9 underrun
    wr(3'd0, 0); wr(3'd6, 7); wr(3'd1, 32'h5000); wr(3'd2, 7); wr(3'd0, 1);
    raw_pop; idle(2);
    rd(3'd6, r); chk(r[1] == 1'b1, "R9", r, 2);
    wr(3'd0, 0); wr(3'd6, 7); raw_pop; idle(2);
    rd(3'd6, r); chk(r == 0, "R9", r, 0);

    // R10 bus error
    err_addr = 32'h6008;
    wr(3'd1, 32'h6000); wr(3'd2, 15); wr(3'd3, 15); wr(3'd6, 7); wr(3'd0, 1);
    idle(30);
    rd(3'd6, r); chk(r == 4, "R10", r, 4);
    chk(!mem_req, "R10", mem_req, 0);
    rd(3'd4, r); chk(r == 32'h6008, "R10", r, 32'h6008);
    popw(32'h6000, "R10"); popw(32'h6004, "R10");
    idle(10);
    chk(smp_empty && !mem_req, "R10", {smp_empty, mem_req}, 2'b10);
    err_addr = 32'hFFFF_FFFF;
    wr(3'd0, 0); wr(3'd0, 1);
    popw(32'h6000, "R10");

    // R11 stop and restart
    idle(30);
    wr(3'd0, 0); idle(10);
    chk(!mem_req && smp_empty, "R11", {mem_req, smp_empty}, 2'b01);
    rd(3'd4, r); chk(r == 32'h6000, "R11", r, 32'h6000);
    wr(3'd0, 1);
    popw(32'h6000, "R11"); popw(32'h6004, "R11");
    wr(3'd0, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end
endmodule